// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Sequencer

This block is the control unit and register set of a small processor built around one shared memory port. It keeps a program counter, an address register that alone drives the memory address, a buffer register that alone carries memory data, an opcode register and an accumulator. Every instruction is carried out as a series of register transfers across several clock cycles. A fetch subcycle runs first. An optional indirect subcycle follows when the instruction asks for it. Then comes an execute subcycle. When an interrupt is pending and enabled, an interrupt subcycle runs last.

The single-ported memory is driven through a request, a write enable, an address and a write-data bus, and it answers with a ready strobe and read data. The sequencer holds in any access state until ready arrives, so memory latency can vary. An interrupt request input is looked at only once per instruction, after execute. When the interrupt is taken, the sequencer saves the program counter to a fixed memory word, clears the interrupt enable bit and jumps to a fixed handler address. A one-cycle retire strobe marks each completed instruction. The register outputs show that instruction's result during the strobe.

Top module: `icyc_seq_top`

## Requirements
- R1: Each fetch copies the program counter into the address register and issues a read at that address. The returned word goes through the buffer register into the instruction register.
- R2: The program counter advances by one when the fetch read completes, wrapping modulo 2^AW.
- R3: An instruction word holds the opcode in its top three bits, the indirect flag in bit AW and the address field in bits AW-1:0. The opcodes are: 0 no operation, 1 load, 2 store, 3 jump, 4 add, 5 enable interrupts. Codes 6 and 7 do nothing.
- R4: When the indirect flag is set, one extra read is made at the address field. The low AW bits of the returned word become the effective address.
- R5: A load places the word at the effective address in the accumulator. It sets the zero flag exactly when that word is zero and clears the carry flag.
- R6: An add places the accumulator plus the word at the effective address, modulo 2^DW, in the accumulator. The carry flag takes the carry out and the zero flag marks a zero sum.
- R7: A store makes exactly one memory write of the accumulator to the effective address and leaves the accumulator and flags unchanged.
- R8: A jump loads the program counter with the effective address. Enable-interrupts sets the interrupt enable bit.
- R9: After each instruction, if the interrupt request and the enable bit are both high, the sequencer writes the program counter, zero-extended, to SAVE_ADDR. It also clears the enable bit and loads HANDLER_ADDR into the program counter before the next fetch. Otherwise the next fetch starts directly.
- R10: An access holds request, address, write enable and write data stable until ready is high, and it completes in that cycle. Write enable is never high without request.
- R11: During reset the program counter is RESET_PC, the accumulator and both flags are zero, the enable bit is IE_AT_RESET, and no request is issued.
- R12: Retire is high for exactly one cycle per instruction, and during that cycle the register outputs show the completed instruction's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory address from the address register |
| mem_wdata | output | DW | Write data from the buffer register |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| pc_o | output | AW | Program counter |
| acc_o | output | DW | Accumulator |
| flag_z | output | 1 | Zero condition code |
| flag_c | output | 1 | Carry condition code |
| int_en | output | 1 | Interrupt enable bit |
| retire | output | 1 | One-cycle instruction completion strobe |

## Verification
A reference model in the bench runs three programs. The results of each retired instruction and every memory write are compared in order. The first program mixes direct and indirect loads, adds that overflow to zero, both store forms, chained jumps and a program counter wrap past the top of memory. Comparing its results separates correct effective-address formation and flag updates from off-by-one or wrong-source transfers. The same program is run again with three wait cycles on every access, which checks that the sequencer holds its state and bus while waiting. A third run keeps the interrupt request high. It shows that interrupts are taken only while enabled, that the saved counter and the handler entry are correct, and that a re-enable triggers an immediate re-entry.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

   localparam int OPW = 3;

   localparam logic [OPW-1:0] OPC_NOP   = 3'd0;
   localparam logic [OPW-1:0] OPC_LOAD  = 3'd1;
   localparam logic [OPW-1:0] OPC_STORE = 3'd2;
   localparam logic [OPW-1:0] OPC_JUMP  = 3'd3;
   localparam logic [OPW-1:0] OPC_ADD   = 3'd4;
   localparam logic [OPW-1:0] OPC_EINT  = 3'd5;

   typedef enum logic [3:0] {
      S_F_ADR, S_F_RD, S_F_IR,
      S_I_ADR, S_I_RD,
      S_X_ADR, S_X_RD, S_X_ALU, S_X_WR,
      S_DONE,
      S_N_ADR, S_N_WR
   } state_t;

   typedef struct packed {
      logic mar_pc;
      logic mar_mbr;
      logic mar_save;
      logic mbr_mem;
      logic mbr_acc;
      logic mbr_pc;
      logic ir_mbr;
      logic pc_inc;
      logic pc_mbr;
      logic pc_hnd;
      logic acc_ld;
      logic acc_add;
      logic ie_set;
      logic ie_clr;
   } ctl_t;

endpackage

// File: rtl/icyc_alu.sv
module icyc_alu #(
   parameter int DW = 12
) (
   input  logic [DW-1:0] acc,
   input  logic [DW-1:0] opnd,
   input  logic          add_sel,
   output logic [DW-1:0] res,
   output logic          cout,
   output logic          zero
);

   logic [DW:0] sum;

   assign sum  = {1'b0, acc} + {1'b0, opnd};
   assign res  = add_sel ? sum[DW-1:0] : opnd;
   assign cout = add_sel & sum[DW];
   assign zero = (res == '0);

endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
   import icyc_pkg::*;
#(
   parameter int              AW           = 8,
   parameter int              DW           = 12,
   parameter logic [AW-1:0]   RESET_PC     = '0,
   parameter logic [AW-1:0]   SAVE_ADDR    = 'h7F,
   parameter logic [AW-1:0]   HANDLER_ADDR = 'h30,
   parameter logic            IE_AT_RESET  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  ctl_t           ctl,
   input  logic [DW-1:0]  mem_rdata,
   input  logic [DW-1:0]  alu_res,
   input  logic           alu_cout,
   input  logic           alu_zero,
   output logic [AW-1:0]  pc,
   output logic [AW-1:0]  mar,
   output logic [DW-1:0]  mbr,
   output logic [OPW-1:0] ir,
   output logic [DW-1:0]  acc,
   output logic           zf,
   output logic           cf,
   output logic           ie
);

   localparam int PADW = DW - AW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= RESET_PC;
         mar <= '0;
         mbr <= '0;
         ir  <= OPC_NOP;
         acc <= '0;
         zf  <= 1'b0;
         cf  <= 1'b0;
         ie  <= IE_AT_RESET;
      end else begin
         if (ctl.mar_pc)        mar <= pc;
         else if (ctl.mar_mbr)  mar <= mbr[AW-1:0];
         else if (ctl.mar_save) mar <= SAVE_ADDR;

         if (ctl.mbr_mem)       mbr <= mem_rdata;
         else if (ctl.mbr_acc)  mbr <= acc;
         else if (ctl.mbr_pc)   mbr <= {{PADW{1'b0}}, pc};

         if (ctl.ir_mbr)        ir <= mbr[DW-1 -: OPW];

         if (ctl.pc_inc)        pc <= pc + AW'(1);
         else if (ctl.pc_mbr)   pc <= mbr[AW-1:0];
         else if (ctl.pc_hnd)   pc <= HANDLER_ADDR;

         if (ctl.acc_ld | ctl.acc_add) begin
            acc <= alu_res;
            zf  <= alu_zero;
            cf  <= alu_cout;
         end

         if (ctl.ie_clr)        ie <= 1'b0;
         else if (ctl.ie_set)   ie <= 1'b1;
      end
   end

   AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.acc_ld |=> ((zf == (acc == '0)) && !cf)) else $error("load flags wrong"); // R5

   AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.mbr_acc |=> ($stable(acc) && $stable(zf) && $stable(cf))) else $error("store touched acc"); // R7

endmodule

// File: rtl/icyc_fsm.sv
module icyc_fsm
   import icyc_pkg::*;
#(
   parameter bit HAS_INDIRECT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           irq,
   input  logic           ie,
   input  logic           mem_ready,
   input  logic           mbr_ind,
   input  logic [OPW-1:0] ir_op,
   output state_t         state_o,
   output ctl_t           ctl,
   output logic           mem_req,
   output logic           mem_we,
   output logic           retire
);

   state_t state, nxt;
   logic   ind_taken;

   generate
      if (HAS_INDIRECT) begin : g_ind
         assign ind_taken = mbr_ind;
      end else begin : g_dir
         assign ind_taken = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_F_ADR;
      else        state <= nxt;
   end

   always_comb begin
      nxt     = state;
      ctl     = '0;
      mem_req = 1'b0;
      mem_we  = 1'b0;
      retire  = 1'b0;
      case (state)
         S_F_ADR: begin
            ctl.mar_pc = 1'b1;
            nxt = S_F_RD;
         end
         S_F_RD: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               ctl.mbr_mem = 1'b1;
               ctl.pc_inc  = 1'b1;
               nxt = S_F_IR;
            end
         end
         S_F_IR: begin
            ctl.ir_mbr = 1'b1;
            nxt = ind_taken ? S_I_ADR : S_X_ADR;
         end
         S_I_ADR: begin
            ctl.mar_mbr = 1'b1;
            nxt = S_I_RD;
         end
         S_I_RD: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               ctl.mbr_mem = 1'b1;
               nxt = S_X_ADR;
            end
         end
         S_X_ADR: begin
            ctl.mar_mbr = 1'b1;
            nxt = S_DONE;
            case (ir_op)
               OPC_LOAD, OPC_ADD: nxt = S_X_RD;
               OPC_STORE: begin
                  ctl.mbr_acc = 1'b1;
                  nxt = S_X_WR;
               end
               OPC_JUMP:  ctl.pc_mbr = 1'b1;
               OPC_EINT:  ctl.ie_set = 1'b1;
               default:   nxt = S_DONE;
            endcase
         end
         S_X_RD: begin
            mem_req = 1'b1;
            if (mem_ready) begin
               ctl.mbr_mem = 1'b1;
               nxt = S_X_ALU;
            end
         end
         S_X_ALU: begin
            ctl.acc_add = (ir_op == OPC_ADD);
            ctl.acc_ld  = (ir_op != OPC_ADD);
            nxt = S_DONE;
         end
         S_X_WR: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ready) nxt = S_DONE;
         end
         S_DONE: begin
            retire = 1'b1;
            nxt = (irq && ie) ? S_N_ADR : S_F_ADR;
         end
         S_N_ADR: begin
            ctl.mbr_pc   = 1'b1;
            ctl.mar_save = 1'b1;
            ctl.ie_clr   = 1'b1;
            nxt = S_N_WR;
         end
         S_N_WR: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ready) begin
               ctl.pc_hnd = 1'b1;
               nxt = S_F_ADR;
            end
         end
         default: nxt = S_F_ADR;
      endcase
   end

   assign state_o = state;

   AST_IRQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DONE && irq && ie) |=> (state == S_N_ADR)) else $error("irq not taken"); // R9

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DONE && !(irq && ie)) |=> (state == S_F_ADR)) else $error("irq taken while masked"); // R9

   AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire) else $error("retire longer than one cycle"); // R12

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> $stable(state)) else $error("state moved while waiting"); // R10

endmodule

// File: rtl/icyc_seq_top.sv
module icyc_seq_top
   import icyc_pkg::*;
#(
   parameter int            AW           = 8,
   parameter logic [AW-1:0] RESET_PC     = '0,
   parameter logic [AW-1:0] SAVE_ADDR    = 'h7F,
   parameter logic [AW-1:0] HANDLER_ADDR = 'h30,
   parameter logic          IE_AT_RESET  = 1'b1,
   parameter bit            HAS_INDIRECT = 1'b1,
   localparam int           DW           = OPW + 1 + AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ready,
   output logic [AW-1:0] pc_o,
   output logic [DW-1:0] acc_o,
   output logic          flag_z,
   output logic          flag_c,
   output logic          int_en,
   output logic          retire
);

   localparam int PADW = DW - AW;

   generate
      if (AW < 4 || AW > 16) begin : g_bad_aw
         $error("icyc_seq_top: AW must lie in 4..16");
      end
      if (SAVE_ADDR == HANDLER_ADDR) begin : g_bad_vec
         $error("icyc_seq_top: save word and handler entry must differ");
      end
   endgenerate

   state_t         st;
   ctl_t           ctl;
   logic [AW-1:0]  pc, mar;
   logic [DW-1:0]  mbr, acc, alu_res;
   logic [OPW-1:0] ir;
   logic           zf, cf, ie, alu_cout, alu_zero;

   icyc_fsm #(.HAS_INDIRECT(HAS_INDIRECT)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq       (irq),
      .ie        (ie),
      .mem_ready (mem_ready),
      .mbr_ind   (mbr[AW]),
      .ir_op     (ir),
      .state_o   (st),
      .ctl       (ctl),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .retire    (retire)
   );

   icyc_alu #(.DW(DW)) u_alu (
      .acc     (acc),
      .opnd    (mbr),
      .add_sel (ctl.acc_add),
      .res     (alu_res),
      .cout    (alu_cout),
      .zero    (alu_zero)
   );

   icyc_regs #(
      .AW(AW), .DW(DW), .RESET_PC(RESET_PC), .SAVE_ADDR(SAVE_ADDR),
      .HANDLER_ADDR(HANDLER_ADDR), .IE_AT_RESET(IE_AT_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .mem_rdata (mem_rdata),
      .alu_res   (alu_res),
      .alu_cout  (alu_cout),
      .alu_zero  (alu_zero),
      .pc        (pc),
      .mar       (mar),
      .mbr       (mbr),
      .ir        (ir),
      .acc       (acc),
      .zf        (zf),
      .cf        (cf),
      .ie        (ie)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign pc_o      = pc;
   assign acc_o     = acc;
   assign flag_z    = zf;
   assign flag_c    = cf;
   assign int_en    = ie;

   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_F_RD) |-> (mem_addr == pc && !mem_we)) else $error("fetch address wrong"); // R1

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_F_RD && mem_ready) |=> (pc == $past(pc) + AW'(1))) else $error("pc not stepped"); // R2

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))) else $error("bus moved while waiting"); // R10

   AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req) else $error("write without request"); // R10

   AST_SAVE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_N_WR) |-> (mem_addr == SAVE_ADDR && mem_wdata == {{PADW{1'b0}}, pc} && !ie))
      else $error("interrupt save wrong"); // R9

   AST_HANDLER_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_N_WR && mem_ready) |=> (pc == HANDLER_ADDR)) else $error("handler entry wrong"); // R9

endmodule

// File: tb/tb_icyc_seq_top.sv
module tb_icyc_seq_top;

   localparam int          AW   = 8;
   localparam int          DW   = 12;
   localparam logic [7:0]  SAVE = 8'h7F;
   localparam logic [7:0]  HND  = 8'h30;

   typedef struct { logic [7:0] pc; logic [11:0] acc; logic z; logic c; logic ie; } ret_t;
   typedef struct { logic [7:0] addr; logic [11:0] data; } wr_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq = 1'b0;
   logic mem_req, mem_we, mem_ready, flag_z, flag_c, int_en, retire;
   logic [AW-1:0] mem_addr, pc_o;
   logic [DW-1:0] mem_wdata, mem_rdata, acc_o;

   logic [11:0] mem [256];
   logic [11:0] sh  [256];
   int stall_cfg = 0;
   int wait_ctr  = 0;
   int checks = 0;
   int errors = 0;
   int ret_seen = 0;
   ret_t exp_ret[$];
   wr_t  exp_wr[$];
   logic       prev_wait = 1'b0;
   logic [7:0] prev_addr;
   logic [11:0] prev_wdata;
   logic       prev_we;

   always #5 clk = ~clk;

   icyc_seq_top dut (
      .clk(clk), .rst_n(rst_n), .irq(irq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .pc_o(pc_o), .acc_o(acc_o), .flag_z(flag_z), .flag_c(flag_c),
      .int_en(int_en), .retire(retire)
   );

   // memory model with configurable wait cycles
   assign mem_ready = mem_req && (wait_ctr == 0);
   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (!mem_req) wait_ctr <= stall_cfg;
      else if (wait_ctr != 0) wait_ctr <= wait_ctr - 1;
      else begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         wait_ctr <= stall_cfg;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [11:0] mk(input logic [2:0] op, input logic ind, input logic [7:0] a);
      return {op, ind, a};
   endfunction

   task automatic put(input logic [7:0] a, input logic [11:0] w);
      mem[a] = w;
      sh[a]  = w;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) put(8'(i), 12'h000);
   endtask

   // driver side of the scoreboard: reference model pushes expected items
   task automatic predict(input int n, input logic irq_lvl);
      logic [7:0]  p;
      logic [11:0] a;
      logic        z, c, ie;
      p = 8'h00; a = '0; z = 1'b0; c = 1'b0; ie = 1'b1;
      for (int i = 0; i < n; i++) begin
         logic [11:0] w;
         logic [7:0]  ea;
         logic [12:0] s;
         w  = sh[p];
         ea = w[7:0];
         p  = p + 8'd1;
         if (w[8]) ea = sh[ea][7:0];
         case (w[11:9])
            3'd1: begin a = sh[ea]; z = (a == 0); c = 1'b0; end
            3'd4: begin s = {1'b0, a} + {1'b0, sh[ea]}; a = s[11:0]; c = s[12]; z = (a == 0); end
            3'd2: begin sh[ea] = a; exp_wr.push_back('{ea, a}); end
            3'd3: p = ea;
            3'd5: ie = 1'b1;
            default: ;
         endcase
         exp_ret.push_back('{p, a, z, c, ie});
         if (irq_lvl && ie && i < n - 1) begin
            exp_wr.push_back('{SAVE, {4'h0, p}});
            sh[SAVE] = {4'h0, p};
            ie = 1'b0;
            p  = HND;
         end
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (retire) begin
            ret_t e;
            ret_seen++;
            if (exp_ret.size() == 0) chk(1'b0, "R12 unexpected retire", 32'(pc_o), 32'hFFFF);
            else begin
               e = exp_ret.pop_front();
               // R1 R2 R3 R4 R8: program counter after each instruction
               chk(pc_o == e.pc, "R2 pc at retire", 32'(pc_o), 32'(e.pc));
               // R5 R6: accumulator and condition codes
               chk(acc_o == e.acc, "R5 acc at retire", 32'(acc_o), 32'(e.acc));
               chk(flag_z == e.z, "R5 zero flag", 32'(flag_z), 32'(e.z));
               chk(flag_c == e.c, "R6 carry flag", 32'(flag_c), 32'(e.c));
               chk(int_en == e.ie, "R8 interrupt enable", 32'(int_en), 32'(e.ie));
            end
         end
         if (mem_req && mem_we && mem_ready) begin
            wr_t x;
            if (exp_wr.size() == 0) chk(1'b0, "R7 unexpected write", 32'(mem_addr), 32'hFFFF);
            else begin
               x = exp_wr.pop_front();
               // R7 stores and R9 interrupt saves, in order
               chk(mem_addr == x.addr, "R7 write address", 32'(mem_addr), 32'(x.addr));
               chk(mem_wdata == x.data, "R9 write data", 32'(mem_wdata), 32'(x.data));
            end
         end
         if (prev_wait) begin
            chk(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wdata,
                "R10 bus held while waiting", {mem_req, 3'b0, mem_addr}, {1'b1, 3'b0, prev_addr});
         end
         chk(!mem_we || mem_req, "R10 write without request", 32'(mem_we), 32'(0));
         prev_wait  = mem_req && !mem_ready;
         prev_addr  = mem_addr;
         prev_we    = mem_we;
         prev_wdata = mem_wdata;
      end else begin
         prev_wait = 1'b0;
      end
   end

   task automatic run(input int stall, input logic irq_lvl, input int n);
      rst_n = 1'b0;
      irq = irq_lvl;
      stall_cfg = stall;
      ret_seen = 0;
      exp_ret.delete();
      exp_wr.delete();
      repeat (2) @(negedge clk);
      // R11 reset state
      chk(pc_o == 8'h00, "R11 reset pc", 32'(pc_o), 32'(0));
      chk(acc_o == 12'h000 && !flag_z && !flag_c, "R11 reset acc and flags", {flag_z, flag_c, acc_o}, 32'(0));
      chk(int_en == 1'b1, "R11 reset enable", 32'(int_en), 32'(1));
      chk(!mem_req, "R11 no request in reset", 32'(mem_req), 32'(0));
      predict(n, irq_lvl);
      rst_n = 1'b1;
      wait (ret_seen == n);
      @(negedge clk);
      rst_n = 1'b0;
      chk(exp_ret.size() == 0, "R12 all retires seen", 32'(exp_ret.size()), 32'(0));
      chk(exp_wr.size() == 0, "R7 all writes seen", 32'(exp_wr.size()), 32'(0));
   endtask

   task automatic load_prog_a();
      clear_mem();
      put(8'h00, mk(3'd1, 1'b0, 8'h40));
      put(8'h01, mk(3'd4, 1'b0, 8'h41));
      put(8'h02, mk(3'd4, 1'b0, 8'h42));
      put(8'h03, mk(3'd1, 1'b1, 8'h43));
      put(8'h04, mk(3'd2, 1'b0, 8'h50));
      put(8'h05, mk(3'd2, 1'b1, 8'h45));
      put(8'h06, mk(3'd3, 1'b0, 8'h10));
      put(8'h10, mk(3'd3, 1'b1, 8'h46));
      put(8'h20, mk(3'd1, 1'b0, 8'h50));
      put(8'h21, mk(3'd5, 1'b0, 8'h00));
      put(8'h22, mk(3'd6, 1'b0, 8'h00));
      put(8'h23, mk(3'd3, 1'b0, 8'hFE));
      put(8'hFE, mk(3'd1, 1'b0, 8'h42));
      put(8'hFF, mk(3'd0, 1'b0, 8'h00));
      put(8'h41, 12'hFFF);
      put(8'h42, 12'h001);
      put(8'h43, 12'h044);
      put(8'h44, 12'h123);
      put(8'h45, 12'h051);
      put(8'h46, 12'h020);
   endtask

   task automatic load_prog_b();
      clear_mem();
      put(8'h00, mk(3'd1, 1'b0, 8'h41));
      put(8'h30, mk(3'd4, 1'b0, 8'h42));
      put(8'h31, mk(3'd1, 1'b0, 8'h7F));
      put(8'h32, mk(3'd5, 1'b0, 8'h00));
      put(8'h41, 12'hFFF);
      put(8'h42, 12'h001);
   endtask

   initial begin
      // R3 R4 R5 R6 R7 R8 R2 wrap: mixed program, memory answers at once
      load_prog_a();
      run(0, 1'b0, 15);
      // R10: same program with three wait cycles per access
      load_prog_a();
      run(3, 1'b0, 15);
      // R9: interrupt request held high, handler re-enables
      load_prog_b();
      run(2, 1'b1, 8);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", ret_seen, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule